// File: doc/BRIEF.md
# I/O Channel Processor Instruction Decoder

This block takes the first bytes of one instruction of a channel-style I/O processor, together with the 20-bit address of its first byte, and produces a decoded record. The record holds the header fields, a class code, the total length in bytes, the optional offset byte, the immediate value, the 20-bit relative branch target and, for the load-pointer-immediate form, a 20-bit physical address. Combinations of fields that the processor does not accept are flagged invalid. They are still given a length of 2, so a fetch sequencer can always advance.

The decode itself is combinational. One output register stands behind a valid/ready pair. A new instruction is accepted whenever the register is empty or is being drained in the same cycle, so the block sustains one decode per clock. Instruction byte k is presented on `in_bytes[8k+7:8k]`. Bytes beyond the decoded length are ignored.

Top module: `iop_insn_decoder`

## Requirements
- R1: Header split: byte 0 bits 7:5 give `out_reg`, bits 4:3 give `out_isz`, bits 2:1 give `out_mode`, and bit 0 gives `out_wide`. Byte 1 bits 7:2 give `out_opc` and bits 1:0 give `out_base`. All six are reported for every instruction, valid or not.
- R2: `in_ready` is high whenever the output register is empty or `out_ready` is high. An instruction is accepted on a clock edge with `in_valid` and `in_ready` both high, and appears on the outputs with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, every output holds still. After reset, `out_valid` is low and `in_ready` is high.
- R3: The length is 2 header bytes, plus an offset byte when a memory form uses mode 1, plus the immediate bytes. Size code 1 adds one immediate byte and size code 2 adds two. Test-and-set adds two bytes and load-pointer-immediate adds four. Register forms never take an offset byte.
- R4: The offset byte is byte 2 when present, and `out_has_ofs` marks it (otherwise `out_ofs` is 0). The immediate starts right after any offset byte. A 1-byte value is zero-extended into `out_imm`. A 2-byte value is little-endian. For test-and-set, `out_imm` is its 8-bit immediate. Branches report their raw displacement.
- R5: Opcode 0x00 is valid only when `out_base`, `out_wide`, `out_mode` and `out_isz` are all zero and the register field is not 1. Opcode 0x12 (halt) is valid only with the same zero fields and a register field of 1. Both have class 0 (control).
- R6: For class 4 (branch) and class 5 (call), `out_target` = address + length + displacement, modulo 2^20. The displacement is sign-extended from 8 bits (size code 1, and test-and-set) or from 16 bits (size code 2). For every other class, `out_target` is 0.
- R7: Opcode 0x08 needs base selector 0. With register field 4 and mode 0, it is a short jump (width 0, size 1) or a long jump (width 1, size 2), both class 4. Otherwise it is an add-immediate of class 1 (width 0 with size 1, or width 1 with size 2). Any other combination is invalid.
- R8: Opcode 0x02 (load pointer immediate, class 6) needs width 1, mode 0 and size code 2. It carries a 16-bit offset and then a 16-bit segment. `out_phys` = (segment·16 + offset) mod 2^20, and `out_imm` is the offset. `out_phys` is 0 for every other class.
- R9: Opcode 0x25 (test-and-set, class 4) needs size code 3, width 0 and register field 0. Its 8-bit immediate is followed by an 8-bit signed displacement.
- R10: Register-immediate opcodes 0x09, 0x0A and 0x0C (class 1) need base selector 0 and either width 0 with size 1 or width 1 with size 2. Register-only opcodes 0x0B, 0x0E and 0x0F (class 2) need the same all-zero fields as opcode 0x00. Register branches 0x10 and 0x11 (class 4) need base selector 0, width 0 and size 1 or 2.
- R11: These are memory forms (class 3). Opcodes 0x13 and 0x30–0x32 need width 0 with size 1, or width 1 with size 2. Opcodes 0x20, 0x21, 0x28–0x2B, 0x34–0x37, 0x3A and 0x3B need size 0. Opcodes 0x22, 0x23 and 0x26 need width 1 with size 0. Opcodes 0x3D and 0x3E need width 0 with size 0. The memory branches are class 4. Opcodes 0x2C and 0x2D need width 0, size 1 or 2, and register field 0. Opcodes 0x2E and 0x2F need width 0 with size 1 or 2. Opcodes 0x38 and 0x39 need size 1 or 2.
- R12: Opcode 0x27 (call, class 5) needs width 1, register field 4 and size code 1 or 2.
- R13: Every other opcode, and every combination not allowed above, gives class 7 with `out_invalid` high, length 2, and zero offset, immediate, target and physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction bytes and address are valid |
| in_ready | output | 1 | Decoder can accept an instruction |
| in_addr | input | 20 | Address of the first instruction byte |
| in_bytes | input | 48 | Instruction bytes, byte k at bits 8k+7:8k |
| out_ready | input | 1 | Consumer takes the decoded record |
| out_valid | output | 1 | Decoded record is valid |
| out_reg | output | 3 | Register / bit-number field |
| out_isz | output | 2 | Immediate-size code |
| out_mode | output | 2 | Addressing mode |
| out_wide | output | 1 | Word-width flag |
| out_opc | output | 6 | Opcode |
| out_base | output | 2 | Memory-base selector |
| out_class | output | 3 | 0 control, 1 reg-imm, 2 reg-only, 3 memory, 4 branch, 5 call, 6 load-pointer-imm, 7 invalid |
| out_len | output | 3 | Instruction length in bytes (2 to 6) |
| out_has_ofs | output | 1 | Offset byte present |
| out_ofs | output | 8 | Offset byte |
| out_imm | output | 16 | Immediate or raw displacement |
| out_target | output | 20 | Relative branch target |
| out_phys | output | 20 | Load-pointer-immediate physical address |
| out_invalid | output | 1 | Invalid encoding |

## Verification
The properties assume that `rst_n` is applied for at least one clock before traffic starts. They also assume that `out_ready` is the only thing that can stall the output register, so any cycle with `out_valid` high and `out_ready` low is a legal hold. The stimulus drives fully known bytes and addresses on every cycle. It covers all 65536 header pairs, with trailing bytes and addresses derived from the header, so both displacement signs and 20-bit address wrap-around occur. `out_ready` is lowered only in a dedicated hold sequence.

// File: rtl/iop_insn_decoder.sv
module iop_insn_decoder #(
  parameter int AW = 20,
  parameter int NB = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [AW-1:0]   in_addr,
  input  logic [8*NB-1:0] in_bytes,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [2:0]      out_reg,
  output logic [1:0]      out_isz,
  output logic [1:0]      out_mode,
  output logic            out_wide,
  output logic [5:0]      out_opc,
  output logic [1:0]      out_base,
  output logic [2:0]      out_class,
  output logic [2:0]      out_len,
  output logic            out_has_ofs,
  output logic [7:0]      out_ofs,
  output logic [15:0]     out_imm,
  output logic [AW-1:0]   out_target,
  output logic [AW-1:0]   out_phys,
  output logic            out_invalid
);
  localparam logic [2:0] C_CTRL = 3'd0, C_RIMM = 3'd1, C_RONLY = 3'd2, C_MEM = 3'd3,
                         C_BR = 3'd4, C_CALL = 3'd5, C_LPI = 3'd6, C_INV = 3'd7;

  logic [7:0] bt [NB];
  for (genvar k = 0; k < NB; k++) begin : g_bt
    assign bt[k] = in_bytes[8*k +: 8];
  end

  wire [2:0] f_reg  = bt[0][7:5];
  wire [1:0] f_isz  = bt[0][4:3];
  wire [1:0] f_mode = bt[0][2:1];
  wire       f_wide = bt[0][0];
  wire [5:0] f_opc  = bt[1][7:2];
  wire [1:0] f_base = bt[1][1:0];

  wire imm_b = !f_wide && f_isz == 2'd1;
  wire imm_w = f_wide && f_isz == 2'd2;
  wire dsz   = f_isz == 2'd1 || f_isz == 2'd2;
  wire bare  = f_base == 2'd0 && !f_wide && f_mode == 2'd0 && f_isz == 2'd0;
  wire b0    = f_base == 2'd0;

  logic       ok, memf, tsl, lpi;
  logic [2:0] cls;

  always_comb begin
    ok = 1'b0; memf = 1'b0; tsl = 1'b0; lpi = 1'b0; cls = C_INV;
    case (f_opc)
      6'h00: begin cls = C_CTRL; ok = bare && f_reg != 3'd1; end
      6'h12: begin cls = C_CTRL; ok = bare && f_reg == 3'd1; end
      6'h02: begin cls = C_LPI; lpi = 1'b1; ok = f_wide && f_mode == 2'd0 && f_isz == 2'd2; end
      6'h08: begin
        if (b0 && f_reg == 3'd4 && f_mode == 2'd0 && (imm_b || imm_w)) begin
          cls = C_BR; ok = 1'b1;
        end else begin
          cls = C_RIMM; ok = b0 && (imm_b || imm_w);
        end
      end
      6'h09, 6'h0a, 6'h0c: begin cls = C_RIMM; ok = b0 && (imm_b || imm_w); end
      6'h0b, 6'h0e, 6'h0f: begin cls = C_RONLY; ok = bare; end
      6'h10, 6'h11: begin cls = C_BR; ok = b0 && !f_wide && dsz; end
      6'h13, 6'h30, 6'h31, 6'h32: begin cls = C_MEM; memf = 1'b1; ok = imm_b || imm_w; end
      6'h20, 6'h21, 6'h28, 6'h29, 6'h2a, 6'h2b,
      6'h34, 6'h35, 6'h36, 6'h37, 6'h3a, 6'h3b: begin
        cls = C_MEM; memf = 1'b1; ok = f_isz == 2'd0;
      end
      6'h22, 6'h23, 6'h26: begin cls = C_MEM; memf = 1'b1; ok = f_wide && f_isz == 2'd0; end
      6'h3d, 6'h3e: begin cls = C_MEM; memf = 1'b1; ok = !f_wide && f_isz == 2'd0; end
      6'h25: begin
        cls = C_BR; memf = 1'b1; tsl = 1'b1;
        ok = !f_wide && f_isz == 2'd3 && f_reg == 3'd0;
      end
      6'h27: begin cls = C_CALL; memf = 1'b1; ok = f_wide && f_reg == 3'd4 && dsz; end
      6'h2c, 6'h2d: begin cls = C_BR; memf = 1'b1; ok = !f_wide && dsz && f_reg == 3'd0; end
      6'h2e, 6'h2f: begin cls = C_BR; memf = 1'b1; ok = !f_wide && dsz; end
      6'h38, 6'h39: begin cls = C_BR; memf = 1'b1; ok = dsz; end
      default: ok = 1'b0;
    endcase
  end

  wire       has_ofs = ok && memf && f_mode == 2'd1;
  wire [2:0] imm_n   = lpi ? 3'd4 : tsl ? 3'd2 :
                       f_isz == 2'd1 ? 3'd1 : f_isz == 2'd2 ? 3'd2 : 3'd0;
  wire [2:0] len     = ok ? 3'd2 + {2'b0, has_ofs} + imm_n : 3'd2;
  wire [7:0] pb0     = has_ofs ? bt[3] : bt[2];
  wire [7:0] pb1     = has_ofs ? bt[4] : bt[3];
  wire       is_br   = ok && (cls == C_BR || cls == C_CALL);

  logic [15:0] imm;
  always_comb begin
    imm = 16'h0;
    if (ok) begin
      if (lpi)                          imm = {bt[3], bt[2]};
      else if (tsl || f_isz == 2'd1)    imm = {8'h0, pb0};
      else if (f_isz == 2'd2)           imm = {pb1, pb0};
    end
  end

  wire [15:0]   disp = tsl ? {{8{pb1[7]}}, pb1} :
                       f_isz == 2'd1 ? {{8{pb0[7]}}, pb0} : {pb1, pb0};
  wire [AW-1:0] tgt  = in_addr + AW'(len) + {{(AW-16){disp[15]}}, disp};
  wire [AW-1:0] phys = {bt[5], bt[4], 4'h0} + {4'h0, bt[3], bt[2]};

  assign in_ready = !out_valid || out_ready;
  wire take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_reg <= '0; out_isz <= '0; out_mode <= '0; out_wide <= 1'b0;
      out_opc <= '0; out_base <= '0; out_class <= '0; out_len <= '0;
      out_has_ofs <= 1'b0; out_ofs <= '0; out_imm <= '0;
      out_target <= '0; out_phys <= '0; out_invalid <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_reg     <= f_reg;
        out_isz     <= f_isz;
        out_mode    <= f_mode;
        out_wide    <= f_wide;
        out_opc     <= f_opc;
        out_base    <= f_base;
        out_class   <= ok ? cls : C_INV;
        out_len     <= len;
        out_has_ofs <= has_ofs;
        out_ofs     <= has_ofs ? bt[2] : 8'h0;
        out_imm     <= imm;
        out_target  <= is_br ? tgt : '0;
        out_phys    <= (ok && lpi) ? phys : '0;
        out_invalid <= !ok;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iop_insn_decoder_chk.sv
module iop_insn_decoder_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_ready,
  input logic          out_valid,
  input logic [2:0]    out_reg,
  input logic [1:0]    out_isz,
  input logic [1:0]    out_mode,
  input logic          out_wide,
  input logic [5:0]    out_opc,
  input logic [1:0]    out_base,
  input logic [2:0]    out_class,
  input logic [2:0]    out_len,
  input logic          out_has_ofs,
  input logic [7:0]    out_ofs,
  input logic [15:0]   out_imm,
  input logic [AW-1:0] out_target,
  input logic [AW-1:0] out_phys,
  input logic          out_invalid
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_target)
      && $stable(out_opc) && $stable(out_imm) && $stable(out_class));

  p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len >= 3'd2 && out_len <= 3'd6);

  p_ofs_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_has_ofs |-> out_mode == 2'd1);

  p_ofs_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_has_ofs |-> out_ofs == 8'h0);

  p_ctrl_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_opc == 6'h00 && !out_invalid |->
      out_reg != 3'd1 && out_isz == 2'd0 && out_mode == 2'd0 && !out_wide && out_base == 2'd0);

  p_no_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class != 3'd4 && out_class != 3'd5 |-> out_target == '0);

  p_phys_only_lpi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class != 3'd6 |-> out_phys == '0);

  p_call_fields_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd5 |-> out_wide && out_reg == 3'd4 && (out_isz == 2'd1 || out_isz == 2'd2));

  p_invalid_len_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_len == 3'd2 && out_class == 3'd7 && out_imm == 16'h0);
endmodule

bind iop_insn_decoder iop_insn_decoder_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .out_ready(out_ready), .out_valid(out_valid),
  .out_reg(out_reg), .out_isz(out_isz), .out_mode(out_mode), .out_wide(out_wide),
  .out_opc(out_opc), .out_base(out_base), .out_class(out_class), .out_len(out_len),
  .out_has_ofs(out_has_ofs), .out_ofs(out_ofs), .out_imm(out_imm),
  .out_target(out_target), .out_phys(out_phys), .out_invalid(out_invalid)
);

// File: tb/iop_insn_decoder_tb_top.sv
`timescale 1ns/1ps
module iop_insn_decoder_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, in_valid, in_ready, out_ready, out_valid;
  logic [19:0] in_addr;
  logic [47:0] in_bytes;
  logic [2:0]  out_reg, out_class, out_len;
  logic [1:0]  out_isz, out_mode, out_base;
  logic        out_wide, out_has_ofs, out_invalid;
  logic [5:0]  out_opc;
  logic [7:0]  out_ofs;
  logic [15:0] out_imm;
  logic [19:0] out_target, out_phys;

  iop_insn_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_bytes(in_bytes), .out_ready(out_ready), .out_valid(out_valid),
    .out_reg(out_reg), .out_isz(out_isz), .out_mode(out_mode), .out_wide(out_wide),
    .out_opc(out_opc), .out_base(out_base), .out_class(out_class), .out_len(out_len),
    .out_has_ofs(out_has_ofs), .out_ofs(out_ofs), .out_imm(out_imm),
    .out_target(out_target), .out_phys(out_phys), .out_invalid(out_invalid)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_byte(input logic [15:0] h, input int k);
    case (k)
      0: return h[7:0];
      1: return h[15:8];
      2: return h[7:0] ^ 8'hA5;
      3: return h[15:8] + 8'h3C;
      4: return ~h[7:0];
      default: return h[15:8] ^ h[7:0];
    endcase
  endfunction

  function automatic logic [19:0] tb_addr(input logic [15:0] h);
    return {h[3:0], h};
  endfunction

  function automatic string grp_tag(input logic [5:0] o);
    if (o == 6'h00 || o == 6'h12) return "R5";
    if (o == 6'h08) return "R7";
    if (o == 6'h02) return "R8";
    if (o == 6'h25) return "R9";
    if (o == 6'h27) return "R12";
    if (o inside {6'h09, 6'h0a, 6'h0b, 6'h0c, 6'h0e, 6'h0f, 6'h10, 6'h11}) return "R10";
    if (o >= 6'h13) return "R11";
    return "R13";
  endfunction

  task automatic drive(input logic [15:0] h);
    for (int k = 0; k < 6; k++) in_bytes[8*k +: 8] = tb_byte(h, k);
    in_addr = tb_addr(h);
  endtask

  task automatic expect_all(input logic [15:0] h);
    logic [7:0] bb [6];
    logic [2:0] r; logic [1:0] s, m, bs; logic w; logic [5:0] o;
    int cls, nofs, immc, len, p, disp, t;
    bit memf, tslf, ok;
    logic [15:0] e_imm; logic [19:0] e_tgt, e_phys, a;
    for (int k = 0; k < 6; k++) bb[k] = tb_byte(h, k);
    a = tb_addr(h);
    r = bb[0][7:5]; s = bb[0][4:3]; m = bb[0][2:1]; w = bb[0][0];
    o = bb[1][7:2]; bs = bb[1][1:0];
    memf = 0; tslf = 0; ok = 0; cls = 7;
    if (o == 6'h00) begin ok = (bs == 0 && !w && m == 0 && s == 0 && r != 1); cls = 0; end
    else if (o == 6'h12) begin ok = (bs == 0 && !w && m == 0 && s == 0 && r == 1); cls = 0; end
    else if (o == 6'h02) begin ok = (w && m == 0 && s == 2); cls = 6; end
    else if (o == 6'h08) begin
      if (bs != 0) ok = 0;
      else if (r == 4 && m == 0 && !w && s == 1) begin ok = 1; cls = 4; end
      else if (r == 4 && m == 0 && w && s == 2) begin ok = 1; cls = 4; end
      else begin ok = (!w && s == 1) || (w && s == 2); cls = 1; end
    end
    else if (o inside {6'h09, 6'h0a, 6'h0c}) begin ok = bs == 0 && ((!w && s == 1) || (w && s == 2)); cls = 1; end
    else if (o inside {6'h0b, 6'h0e, 6'h0f}) begin ok = (bs == 0 && !w && m == 0 && s == 0); cls = 2; end
    else if (o inside {6'h10, 6'h11}) begin ok = bs == 0 && !w && (s == 1 || s == 2); cls = 4; end
    else begin
      memf = 1;
      if (o inside {6'h13, 6'h30, 6'h31, 6'h32}) begin ok = (!w && s == 1) || (w && s == 2); cls = 3; end
      else if (o inside {6'h20, 6'h21, 6'h28, 6'h29, 6'h2a, 6'h2b, 6'h34, 6'h35, 6'h36, 6'h37, 6'h3a, 6'h3b})
        begin ok = s == 0; cls = 3; end
      else if (o inside {6'h22, 6'h23, 6'h26}) begin ok = w && s == 0; cls = 3; end
      else if (o inside {6'h3d, 6'h3e}) begin ok = !w && s == 0; cls = 3; end
      else if (o == 6'h25) begin ok = !w && s == 3 && r == 0; cls = 4; tslf = 1; end
      else if (o == 6'h27) begin ok = w && r == 4 && (s == 1 || s == 2); cls = 5; end
      else if (o inside {6'h2c, 6'h2d}) begin ok = !w && r == 0 && (s == 1 || s == 2); cls = 4; end
      else if (o inside {6'h2e, 6'h2f}) begin ok = !w && (s == 1 || s == 2); cls = 4; end
      else if (o inside {6'h38, 6'h39}) begin ok = (s == 1 || s == 2); cls = 4; end
      else ok = 0;
    end
    if (!ok) cls = 7;
    nofs = (ok && memf && m == 1) ? 1 : 0;
    p = 2 + nofs;
    if (cls == 6) immc = 4;
    else if (tslf) immc = 2;
    else immc = (s == 1) ? 1 : (s == 2) ? 2 : 0;
    len = ok ? 2 + nofs + immc : 2;
    e_imm = 16'h0; e_tgt = 20'h0; e_phys = 20'h0; disp = 0;
    if (ok) begin
      if (cls == 6) e_imm = {bb[3], bb[2]};
      else if (tslf || s == 1) e_imm = {8'h0, bb[p]};
      else if (s == 2) e_imm = {bb[p+1], bb[p]};
      if (cls == 4 || cls == 5) begin
        if (tslf) disp = int'($signed(bb[p+1]));
        else if (s == 1) disp = int'($signed(bb[p]));
        else disp = int'($signed({bb[p+1], bb[p]}));
        t = int'(a) + len + disp;
        e_tgt = t[19:0];
      end
      if (cls == 6) begin
        t = int'({bb[5], bb[4]}) * 16 + int'({bb[3], bb[2]});
        e_phys = t[19:0];
      end
    end
    chk("R2", "out_valid", 32'(out_valid), 32'd1);
    chk("R1", "fields", {13'h0, out_reg, out_isz, out_mode, out_wide, out_opc, out_base},
        {13'h0, r, s, m, w, o, bs});
    chk(ok ? grp_tag(o) : "R13", "class", 32'(out_class), 32'(cls));
    chk("R13", "invalid", 32'(out_invalid), 32'(!ok));
    chk("R3", "len", 32'(out_len), 32'(len));
    chk("R4", "ofs", {23'h0, out_has_ofs, out_ofs}, {23'h0, nofs[0], (nofs != 0) ? bb[2] : 8'h0});
    chk(tslf ? "R9" : "R4", "imm", 32'(out_imm), 32'(e_imm));
    chk("R6", "target", 32'(out_target), 32'(e_tgt));
    chk("R8", "phys", 32'(out_phys), 32'(e_phys));
  endtask

  task automatic print_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      print_summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_addr = '0; in_bytes = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2", "reset out_valid", 32'(out_valid), 32'd0);
    chk("R2", "reset in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    for (int h = 0; h < 65536; h++) begin
      @(negedge clk);
      in_valid = 1'b1;
      drive(16'(h));
      @(posedge clk);
      #1;
      expect_all(16'(h));
    end

    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R2", "drain out_valid", 32'(out_valid), 32'd0);

    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    drive(16'hB4A0);
    @(posedge clk); #1;
    expect_all(16'hB4A0);
    @(negedge clk);
    drive(16'h9CFE);
    #0.1;
    chk("R2", "stall in_ready", 32'(in_ready), 32'd0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    expect_all(16'hB4A0);
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); #1;
    expect_all(16'h9CFE);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R2", "final out_valid", 32'(out_valid), 32'd0);

    done = 1'b1;
    print_summary();
    $finish;
  end
endmodule